// File: doc/BRIEF.md
# Shared-Bus 32x8 Static RAM

This block is a 32-word by 8-bit storage array for a small processor bus. A 5-bit address selects one word through a full decode. Three active-low controls pick what happens: a chip select, a read strobe that also enables the output, and a write strobe. On the pin side, input and output share one 8-bit data bus. Inside the chip that bus appears as a data-in vector, a data-out vector and an output-enable flag, and the pad ring combines them into a tri-state driver.

Read data comes straight from the array through a multiplexer, with no clock in the path. Writes are committed on a rising edge of the system clock. The read strobe wins over the write strobe: when both are low the block reads and does not write. Reset does not clear the array. While reset is held, writes are blocked.

Top module: `busram32x8`

## Requirements
- R1: With `cs_n`=0 and `rd_n`=0, `bus_oe` is 1 and `bus_out` equals the word stored at `addr` in the same cycle, without waiting for a clock edge.
- R2: With `cs_n`=0, `rd_n`=0 and `wr_n`=0, the block reads as in R1, and no location is written at the clock edge.
- R3: With `cs_n`=0, `rd_n`=1 and `wr_n`=0 at a rising clock edge (and `rst_n`=1), `bus_in` is stored at `addr`. During that write `bus_oe` is 0.
- R4: With `cs_n`=1, `bus_oe` is 0 and no location is written, whatever `rd_n` and `wr_n` are.
- R5: With `cs_n`=0, `rd_n`=1 and `wr_n`=1 (standby), `bus_oe` is 0 and the contents do not change.
- R6: Whenever `bus_oe` is 0, `bus_out` is all zeros.
- R7: A change of `addr` during a read shows on `bus_out` within the same cycle.
- R8: All 32 locations are independent. A write to one address leaves every other address unchanged.
- R9: While `rst_n`=0, no write takes place. Reset does not alter stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; writes commit on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes while low |
| addr | input | 5 | Word address |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe and output enable, active low; overrides the write strobe |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Data-in half of the shared bus |
| bus_out | output | 8 | Data-out half of the shared bus; zero when not driving |
| bus_oe | output | 1 | High when the block drives the shared bus |

## Verification
Read results and the output-enable flag are combinational, so they are due in the same cycle as the control and address change that causes them. A write is due only after the next rising edge, and it shows up on a later read. The bench changes inputs on the falling edge and samples combinational outputs 2 ns later, before the next rising edge. Every effect of a write, or the absence of one, is judged by a read that follows the edge at which the write would have committed.

// File: rtl/busram_pkg.sv
// Package: shared types for the shared-bus RAM.
// Assumes: none; holds the decoded bus-mode encoding only.
package busram_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,  // chip not selected
        MODE_STANDBY = 2'd1,  // selected, neither strobe active
        MODE_READ    = 2'd2,  // selected, read strobe active (wins over write)
        MODE_WRITE   = 2'd3   // selected, only write strobe active
    } bus_mode_e;

endpackage

// File: rtl/busram_mode_dec.sv
// Module: busram_mode_dec
// Decodes the three active-low control pins into one bus mode.
// Assumes: the read strobe has priority over the write strobe.
module busram_mode_dec
    import busram_pkg::*;
(
    input  logic      cs_n,
    input  logic      rd_n,
    input  logic      wr_n,
    output bus_mode_e mode
);

    // Priority decode: deselect, then read, then write, else standby.
    always_comb begin
        if (cs_n)       mode = MODE_IDLE;
        else if (!rd_n) mode = MODE_READ;
        else if (!wr_n) mode = MODE_WRITE;
        else            mode = MODE_STANDBY;
    end

endmodule

// File: rtl/busram_word_store.sv
// Module: busram_word_store
// Register array of DEPTH words. One word is written per enabled rising edge.
// Assumes: contents are not initialised; the synchronous active-low reset
// only blocks writes and never clears data.
module busram_word_store #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] words [DEPTH]
);

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        // Per-word register: loads on a write aimed at this address.
        always_ff @(posedge clk) begin
            if (rst_n && we && (waddr == ADDR_W'(gi))) begin
                words[gi] <= wdata;
            end
        end
    end

endmodule

// File: rtl/busram_read_mux.sv
// Module: busram_read_mux
// Selects the addressed word combinationally and forces zero when disabled.
// Assumes: raddr covers exactly DEPTH entries (full decode).
module busram_read_mux #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [DATA_W-1:0] words [DEPTH],
    input  logic [ADDR_W-1:0] raddr,
    input  logic              en,
    output logic [DATA_W-1:0] dout
);

    // Output select: addressed word when enabled, zero otherwise.
    always_comb begin
        dout = en ? words[raddr] : '0;
    end

endmodule

// File: rtl/busram32x8.sv
// Module: busram32x8
// 32x8 RAM for a shared processor data bus. The bus is split into in, out
// and an output-enable flag. Reads are combinational; writes take a clock edge.
// Assumes: the pad ring builds the tri-state driver from bus_out and bus_oe.
module busram32x8
    import busram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    localparam int DEPTH = 1 << ADDR_W;

    bus_mode_e         mode;
    logic              wr_en;
    logic [DATA_W-1:0] words [DEPTH];

    busram_mode_dec u_dec (
        .cs_n (cs_n),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .mode (mode)
    );

    // Mode to strobe mapping: drive on read, store on write.
    always_comb begin
        bus_oe = (mode == MODE_READ);
        wr_en  = (mode == MODE_WRITE);
    end

    busram_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (addr),
        .wdata (bus_in),
        .words (words)
    );

    busram_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmux (
        .words (words),
        .raddr (addr),
        .en    (bus_oe),
        .dout  (bus_out)
    );

endmodule

// File: rtl/busram32x8_chk.sv
// Module: busram32x8_chk
// Port-level protocol checks for busram32x8, attached by bind.
// Assumes: rst_n is held low over at least one rising edge at start-up.
module busram32x8_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe
);

    logic rd_act;
    logic wr_act;
    assign rd_act = !cs_n && !rd_n;
    assign wr_act = !cs_n && rd_n && !wr_n;

    // R6: an idle output carries zeros
    a_r6_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R4: deselect never drives the bus
    a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

    // R5: standby keeps the bus released
    a_r5_standby_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rd_n && wr_n) |-> !bus_oe);

    // R3: a committed write reads back at the same address next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |=> (!(rd_act && addr == $past(addr)) || bus_out == $past(bus_in)));

    // R2: a read cycle, even with the write strobe low, leaves the word as it was
    a_r2_read_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> (!(rd_act && addr == $past(addr)) || $stable(bus_out)));

endmodule

bind busram32x8 busram32x8_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/busram32x8_tb.sv
module busram32x8_tb;

    localparam int AW = 5;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    localparam logic [1:0] OP_WR   = 2'd0;
    localparam logic [1:0] OP_RD   = 2'd1;
    localparam logic [1:0] OP_BOTH = 2'd2;
    localparam logic [1:0] OP_STBY = 2'd3;

    // {op, addr, data}; read results come from the bench model
    localparam logic [14:0] VEC [12] = '{
        {OP_WR,   5'd0,  8'hA5},
        {OP_WR,   5'd31, 8'h3C},
        {OP_WR,   5'd10, 8'hFF},
        {OP_RD,   5'd0,  8'h00},
        {OP_RD,   5'd31, 8'h00},
        {OP_BOTH, 5'd10, 8'h00},
        {OP_RD,   5'd10, 8'h00},
        {OP_STBY, 5'd0,  8'h11},
        {OP_RD,   5'd0,  8'h00},
        {OP_WR,   5'd10, 8'h00},
        {OP_RD,   5'd10, 8'h00},
        {OP_RD,   5'd31, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_oe;

    logic [DW-1:0] model [DEPTH];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    busram32x8 u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ctl(input logic c, input logic r, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cs_n = c; rd_n = r; wr_n = w; addr = a; bus_in = d;
    endtask

    task automatic go_idle();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ctl(1'b0, 1'b1, 1'b0, a, d);
        #2 chk("R3 oe during write", {7'b0, bus_oe}, 8'h00);
        @(posedge clk);
        model[a] = d;
        go_idle();
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a);
        ctl(1'b0, 1'b0, 1'b1, a, 8'h00);
        #2;
        chk(req, {7'b0, bus_oe}, 8'h01);
        chk(req, bus_out, model[a]);
        go_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state: deselected, bus released (R4, R6)
        repeat (3) @(posedge clk);
        #2;
        chk("R4 oe in reset", {7'b0, bus_oe}, 8'h00);
        chk("R6 out in reset", bus_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // vector walk
        foreach (VEC[i]) begin
            logic [1:0]    op;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            {op, a, d} = VEC[i];
            case (op)
                OP_WR: do_write(a, d);
                OP_RD: do_read("R1 vector read", a);
                OP_BOTH: begin
                    // R2: both strobes low reads; write value must not land
                    ctl(1'b0, 1'b0, 1'b0, a, ~model[a]);
                    #2;
                    chk("R2 both low oe", {7'b0, bus_oe}, 8'h01);
                    chk("R2 both low data", bus_out, model[a]);
                    @(posedge clk);
                    go_idle();
                end
                default: begin
                    // R5: standby releases the bus and stores nothing
                    ctl(1'b0, 1'b1, 1'b1, a, d);
                    #2;
                    chk("R5 standby oe", {7'b0, bus_oe}, 8'h00);
                    chk("R6 standby out", bus_out, 8'h00);
                    @(posedge clk);
                    go_idle();
                end
            endcase
        end

        // R8: fill every word, then read every word
        for (int i = 0; i < DEPTH; i++) do_write(AW'(i), DW'((i * 37 + 5) ^ 8'h5A));
        for (int i = 0; i < DEPTH; i++) do_read("R8 full sweep", AW'(i));

        // R4: deselected with the write strobe low stores nothing
        ctl(1'b1, 1'b1, 1'b0, 5'd7, ~model[7]);
        #2;
        chk("R4 deselect oe", {7'b0, bus_oe}, 8'h00);
        chk("R6 deselect out", bus_out, 8'h00);
        @(posedge clk);
        go_idle();
        // R4: deselected with the read strobe low drives nothing
        ctl(1'b1, 1'b0, 1'b1, 5'd7, 8'h00);
        #2 chk("R4 deselect read oe", {7'b0, bus_oe}, 8'h00);
        go_idle();
        do_read("R4 no write when deselected", 5'd7);

        // R7: address change within one read cycle
        ctl(1'b0, 1'b0, 1'b1, 5'd3, 8'h00);
        #2 chk("R7 first addr", bus_out, model[3]);
        addr = 5'd4;
        #2 chk("R7 moved addr", bus_out, model[4]);
        addr = 5'd30;
        #2 chk("R7 moved again", bus_out, model[30]);
        go_idle();

        // R9: write attempt during reset is blocked; contents survive reset
        @(negedge clk);
        rst_n = 1'b0;
        ctl(1'b0, 1'b1, 1'b0, 5'd5, ~model[5]);
        @(posedge clk);
        go_idle();
        @(negedge clk);
        rst_n = 1'b1;
        do_read("R9 write blocked in reset", 5'd5);
        do_read("R9 contents kept", 5'd6);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule